// File: doc/BRIEF.md
# Dual-Mapped Register-Pair ALU Datapath

This block is the execution datapath of a microcoded 8-bit processor. It is 16 bits wide and is built from four chained 4-bit ALU slices. It has a sixteen-entry by 16-bit two-port register file, a Q register, and a 16-bit ALU. Every program register pair is held twice, in two adjacent entries: the even entry keeps the normal byte order and the odd entry keeps the bytes exchanged. The layout is BC/CB at 0/1, DE/ED at 2/3, HL/LH at 4/5 and the accumulator pair at 6/7. SP sits at 9, the constants 0038h and 3800h sit at 12 and 13, and PC sits at 15. The other entries are scratch.

The upper byte lane always uses the A and B addresses as given. The lower byte lane can change bit 0 of each address. In 8-bit mode it inverts that bit. As a result, one microinstruction writes the destination register in the upper lane and, in the same cycle, writes the matching byte of its swapped copy in the lower lane. A 16-bit update of the normal word takes one microinstruction. A second microinstruction then rewrites the swapped copy: the D input is fed from the A-side word with its two bytes exchanged.

The microcode sequencer, the opcode mapper and the bus interface lie outside this block.

Top module: `pair_datapath`

## Requirements
- R1: After reset is asserted, every register-file entry and the Q register read as zero.
- R2: `instr_i[5:3]` selects the function. The arithmetic codes are 000 for R+S+cin, 001 for S-R-1+cin and 010 for R-S-1+cin. The logic codes are 011 OR, 100 AND, 101 (NOT R) AND S, 110 XOR and 111 XNOR. `instr_i[2:0]` selects the (R,S) operand pair: 000 (A,Q), 001 (A,B), 010 (0,Q), 011 (0,B), 100 (0,A), 101 (D,A), 110 (D,Q), 111 (D,0).
- R3: When `mode8_i`=1, the lower lane uses the A and B addresses with bit 0 inverted. The upper lane uses them unchanged.
- R4: When `mode8_i`=0, the lower lane uses the A address unchanged. It uses the B address unchanged if `byte_sw_i`=0, and with bit 0 forced to 0 if `byte_sw_i`=1.
- R5: `instr_i[8:6]` selects the destination:
  - 000: Q is loaded from F, Y shows F, and no RAM write occurs.
  - 001: nothing is written, and Y shows F.
  - 010: R[B] is loaded from F, and Y shows the A-side word.
  - 011: R[B] is loaded from F, and Y shows F.
  - 100: R[B] is loaded from F shifted right with 0 entering, and Q shifts right with F[0] entering.
  - 101: R[B] is loaded from F shifted right.
  - 110: R[B] is loaded from F shifted left with Q[15] entering, and Q shifts left with 0 entering.
  - 111: R[B] is loaded from F shifted left with 0 entering.
  - For codes 100 to 111, Y shows F. Writes take effect at the rising clock edge. Q changes only under codes 000, 100 and 110.
- R6: When `swap_i`=0, D is `{bus_i, bus_i}`. When `swap_i`=1, D is the A-side word with its two bytes exchanged.
- R7: The slice carries form a chain from `cin_i` upward. In 8-bit mode the upper lane takes `cin_i` instead of the lower-lane carry. `carry_lo_o` is the carry out of bit 7 and `carry_hi_o` is the carry out of bit 15. Both are 0 for the logic functions.
- R8: `zero_o` is 1 when F[15:8] is zero in 8-bit mode, and when F[15:0] is zero in 16-bit mode.
- R9: An 8-bit register move is a single OR with source (0,A) in 8-bit mode, and leaves both copies of the target pair consistent. An 8-bit add between registers is likewise a single instruction that leaves both copies consistent.
- R10: A 16-bit increment of a normal-order pair (ADD, source (0,B), `cin_i`=1), followed by one destination-010 OR with source (D,0) and swap enabled, leaves the swapped entry equal to the byte-exchanged new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 9 | Destination, function and source fields |
| a_addr_i | input | 4 | A read address |
| b_addr_i | input | 4 | B read/write address |
| mode8_i | input | 1 | 1 = 8-bit operation |
| byte_sw_i | input | 1 | Lower-lane B bit-0 clear in 16-bit mode |
| swap_i | input | 1 | D takes the byte-swapped A word |
| cin_i | input | 1 | Carry into the lowest slice |
| bus_i | input | 8 | External data byte |
| y_o | output | 16 | Datapath output |
| carry_lo_o | output | 1 | Carry out of bit 7 |
| carry_hi_o | output | 1 | Carry out of bit 15 |
| zero_o | output | 1 | Zero flag for the selected width |

## Verification
The bench preloads each pair in both byte orders. It then checks that every pair still matches its swapped copy after an 8-bit move, an 8-bit add that wraps to zero, and a 16-bit increment that carries across the byte boundary followed by resynchronisation. A lower lane that does not flip its address bit would corrupt the wrong byte of the swapped copy. Letting the lower-lane carry ripple into the upper lane in 8-bit mode would double-count the carry in the wrapping add, and an unswapped D path would leave the swapped copy wrong. Further vectors cover the shift codes with Q chaining, the no-write and Q-load destinations, the 16-bit byte-switch write, and the zero flag at both widths, so that a misplaced shift fill bit or a stray write shows up on Y.

// File: rtl/pair_dp_pkg.sv
package pair_dp_pkg;
  typedef enum logic [2:0] {
    DST_LOADQ  = 3'd0,
    DST_PASS   = 3'd1,
    DST_WR_SHA = 3'd2,
    DST_WR     = 3'd3,
    DST_SHR_RQ = 3'd4,
    DST_SHR_R  = 3'd5,
    DST_SHL_RQ = 3'd6,
    DST_SHL_R  = 3'd7
  } dst_e;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SUBR  = 3'd1,
    FN_SUBS  = 3'd2,
    FN_OR    = 3'd3,
    FN_AND   = 3'd4,
    FN_NOTRS = 3'd5,
    FN_XOR   = 3'd6,
    FN_XNOR  = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    SRC_A_Q = 3'd0,
    SRC_A_B = 3'd1,
    SRC_Z_Q = 3'd2,
    SRC_Z_B = 3'd3,
    SRC_Z_A = 3'd4,
    SRC_D_A = 3'd5,
    SRC_D_Q = 3'd6,
    SRC_D_Z = 3'd7
  } src_e;
endpackage

// File: rtl/lane_addr_mux.sv
module lane_addr_mux #(
  parameter int AW = 4
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  input  logic          mode8_i,
  input  logic          byte_sw_i,
  output logic [AW-1:0] a_lo_o,
  output logic [AW-1:0] b_lo_o
);
  logic b0;

  always_comb begin
    if (mode8_i)        b0 = ~b_i[0];
    else if (byte_sw_i) b0 = 1'b0;
    else                b0 = b_i[0];
  end

  assign a_lo_o = {a_i[AW-1:1], a_i[0] ^ mode8_i};
  assign b_lo_o = {b_i[AW-1:1], b0};
endmodule

// File: rtl/byte_bank.sv
module byte_bank #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic          we_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] da_o,
  output logic [DW-1:0] db_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[rb_i] <= wd_i;
    end
  end

  assign da_o = mem_q[ra_i];
  assign db_o = mem_q[rb_i];
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import pair_dp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  fn_e          fn_i,
  input  logic         cin_i,
  output logic [W-1:0] f_o,
  output logic         cout_o
);
  logic [W:0] sum;
  logic [W:0] cw;

  assign cw = {{W{1'b0}}, cin_i};

  always_comb begin
    unique case (fn_i)
      FN_ADD:   sum = {1'b0, r_i} + {1'b0, s_i} + cw;
      FN_SUBR:  sum = {1'b0, s_i} + {1'b0, ~r_i} + cw;
      FN_SUBS:  sum = {1'b0, r_i} + {1'b0, ~s_i} + cw;
      FN_OR:    sum = {1'b0, r_i | s_i};
      FN_AND:   sum = {1'b0, r_i & s_i};
      FN_NOTRS: sum = {1'b0, ~r_i & s_i};
      FN_XOR:   sum = {1'b0, r_i ^ s_i};
      default:  sum = {1'b0, ~(r_i ^ s_i)};
    endcase
  end

  assign f_o    = sum[W-1:0];
  assign cout_o = sum[W];
endmodule

// File: rtl/pair_datapath.sv
module pair_datapath
  import pair_dp_pkg::*;
#(
  parameter  int SLICE_W  = 4,
  parameter  int N_SLICES = 4,
  parameter  int AW       = 4,
  localparam int DW       = SLICE_W * N_SLICES,
  localparam int LANE_W   = DW / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [8:0]        instr_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [AW-1:0]     b_addr_i,
  input  logic              mode8_i,
  input  logic              byte_sw_i,
  input  logic              swap_i,
  input  logic              cin_i,
  input  logic [LANE_W-1:0] bus_i,
  output logic [DW-1:0]     y_o,
  output logic              carry_lo_o,
  output logic              carry_hi_o,
  output logic              zero_o
);
  localparam int SPL = N_SLICES / 2;

  dst_e dst;
  fn_e  fn;
  src_e src;

  assign dst = dst_e'(instr_i[8:6]);
  assign fn  = fn_e'(instr_i[5:3]);
  assign src = src_e'(instr_i[2:0]);

  logic [AW-1:0] ra_lo, rb_lo;

  lane_addr_mux #(.AW(AW)) u_amux (
    .a_i       (a_addr_i),
    .b_i       (b_addr_i),
    .mode8_i   (mode8_i),
    .byte_sw_i (byte_sw_i),
    .a_lo_o    (ra_lo),
    .b_lo_o    (rb_lo)
  );

  logic [AW-1:0]     lane_ra [2];
  logic [AW-1:0]     lane_rb [2];
  logic [LANE_W-1:0] lane_da [2];
  logic [LANE_W-1:0] lane_db [2];
  logic              we;
  logic [DW-1:0]     wd;

  assign lane_ra[0] = ra_lo;
  assign lane_rb[0] = rb_lo;
  assign lane_ra[1] = a_addr_i;
  assign lane_rb[1] = b_addr_i;

  // lane 0 = bits LANE_W-1:0, lane 1 = upper bits
  for (genvar l = 0; l < 2; l++) begin : g_lane
    byte_bank #(.AW(AW), .DW(LANE_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ra_i   (lane_ra[l]),
      .rb_i   (lane_rb[l]),
      .we_i   (we),
      .wd_i   (wd[l*LANE_W +: LANE_W]),
      .da_o   (lane_da[l]),
      .db_o   (lane_db[l])
    );
  end

  logic [DW-1:0] rd_a, rd_b, d_word, r_op, s_op, f, q_q, q_nxt;

  assign rd_a = {lane_da[1], lane_da[0]};
  assign rd_b = {lane_db[1], lane_db[0]};

  // swap path taps the A-side word so no loop forms through Y
  assign d_word = swap_i ? {rd_a[LANE_W-1:0], rd_a[DW-1:LANE_W]} : {bus_i, bus_i};

  always_comb begin
    unique case (src)
      SRC_A_Q: begin r_op = rd_a;   s_op = q_q;  end
      SRC_A_B: begin r_op = rd_a;   s_op = rd_b; end
      SRC_Z_Q: begin r_op = '0;     s_op = q_q;  end
      SRC_Z_B: begin r_op = '0;     s_op = rd_b; end
      SRC_Z_A: begin r_op = '0;     s_op = rd_a; end
      SRC_D_A: begin r_op = d_word; s_op = rd_a; end
      SRC_D_Q: begin r_op = d_word; s_op = q_q;  end
      default: begin r_op = d_word; s_op = '0;   end
    endcase
  end

  logic [N_SLICES-1:0] c_in_s, c_out_s;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    if (i == 0) begin : g_first
      assign c_in_s[i] = cin_i;
    end else if (i == SPL) begin : g_lane_edge
      // 8-bit mode cuts the chain at the byte boundary
      assign c_in_s[i] = mode8_i ? cin_i : c_out_s[i-1];
    end else begin : g_chain
      assign c_in_s[i] = c_out_s[i-1];
    end

    alu_slice #(.W(SLICE_W)) u_slice (
      .r_i    (r_op[i*SLICE_W +: SLICE_W]),
      .s_i    (s_op[i*SLICE_W +: SLICE_W]),
      .fn_i   (fn),
      .cin_i  (c_in_s[i]),
      .f_o    (f[i*SLICE_W +: SLICE_W]),
      .cout_o (c_out_s[i])
    );
  end

  always_comb begin
    we    = 1'b1;
    wd    = f;
    q_nxt = q_q;
    y_o   = f;
    unique case (dst)
      DST_LOADQ:  begin we = 1'b0; q_nxt = f; end
      DST_PASS:   we = 1'b0;
      DST_WR_SHA: y_o = rd_a;
      DST_WR:     ;
      DST_SHR_RQ: begin
        wd    = {1'b0, f[DW-1:1]};
        q_nxt = {f[0], q_q[DW-1:1]};
      end
      DST_SHR_R:  wd = {1'b0, f[DW-1:1]};
      DST_SHL_RQ: begin
        wd    = {f[DW-2:0], q_q[DW-1]};
        q_nxt = {q_q[DW-2:0], 1'b0};
      end
      default:    wd = {f[DW-2:0], 1'b0};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_nxt;
  end

  assign carry_lo_o = c_out_s[SPL-1];
  assign carry_hi_o = c_out_s[N_SLICES-1];
  assign zero_o     = mode8_i ? (f[DW-1:LANE_W] == '0) : (f == '0);
endmodule

// File: rtl/pair_datapath_chk.sv
module pair_datapath_chk #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [8:0]    instr_i,
  input logic [AW-1:0] a_addr_i,
  input logic [AW-1:0] b_addr_i,
  input logic          mode8_i,
  input logic          byte_sw_i,
  input logic [AW-1:0] ra_lo,
  input logic [AW-1:0] rb_lo,
  input logic [DW-1:0] q_q,
  input logic [DW-1:0] y_o,
  input logic          zero_o
);
  localparam int HW = DW / 2;

  logic [2:0] dcode;
  assign dcode = instr_i[8:6];

  assert_lo_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode8_i |-> ((ra_lo ^ a_addr_i) == AW'(1)) && ((rb_lo ^ b_addr_i) == AW'(1)));

  assert_lo_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode8_i && !byte_sw_i) |-> (ra_lo == a_addr_i) && (rb_lo == b_addr_i));

  assert_bsw_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode8_i && byte_sw_i) |-> (ra_lo == a_addr_i) && (rb_lo == {b_addr_i[AW-1:1], 1'b0}));

  assert_q_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcode == 3'd1 || dcode == 3'd2 || dcode == 3'd3 || dcode == 3'd5 || dcode == 3'd7)
      |=> $stable(q_q));

  assert_zero_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode8_i && dcode == 3'd3) |-> (zero_o == (y_o == '0)));

  assert_zero_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode8_i && dcode == 3'd3) |-> (zero_o == (y_o[DW-1:HW] == '0)));
endmodule

bind pair_datapath pair_datapath_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .instr_i   (instr_i),
  .a_addr_i  (a_addr_i),
  .b_addr_i  (b_addr_i),
  .mode8_i   (mode8_i),
  .byte_sw_i (byte_sw_i),
  .ra_lo     (ra_lo),
  .rb_lo     (rb_lo),
  .q_q       (q_q),
  .y_o       (y_o),
  .zero_o    (zero_o)
);

// File: tb/pair_datapath_test.sv
module pair_datapath_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  instr_i = '0;
  logic [3:0]  a_addr_i = '0, b_addr_i = '0;
  logic        mode8_i = 1'b0, byte_sw_i = 1'b0, swap_i = 1'b0, cin_i = 1'b0;
  logic [7:0]  bus_i = '0;
  logic [15:0] y_o;
  logic        carry_lo_o, carry_hi_o, zero_o;

  always #5 clk_i = ~clk_i;

  pair_datapath uut (
    .clk_i, .rst_ni, .instr_i, .a_addr_i, .b_addr_i, .mode8_i, .byte_sw_i,
    .swap_i, .cin_i, .bus_i, .y_o, .carry_lo_o, .carry_hi_o, .zero_o
  );

  typedef struct {
    logic [15:0] y;
    logic        c7, c15, z;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  event        chk_ev;
  int          n_vec = 0, n_bad = 0;
  logic [15:0] obs_y;
  logic [15:0] mem_m [16];
  logic [15:0] q_m;

  // monitor
  initial forever begin
    @(chk_ev);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      obs_y = y_o;
      if (y_o !== e.y || carry_lo_o !== e.c7 || carry_hi_o !== e.c15 || zero_o !== e.z) begin
        n_bad++;
        $display("FAIL %s: y=%h c7=%b c15=%b z=%b expected y=%h c7=%b c15=%b z=%b",
                 e.tag, y_o, carry_lo_o, carry_hi_o, zero_o, e.y, e.c7, e.c15, e.z);
      end
    end
  end

  task automatic step(input logic [2:0] d, input logic [2:0] f, input logic [2:0] s,
                      input logic [3:0] a, input logic [3:0] b, input logic m8,
                      input logic bsw, input logic sw, input logic ci,
                      input logic [7:0] bus, input string tag);
    logic [3:0]  alo, blo;
    logic [15:0] ra, rb, dw, r, sv, x, yv, fw, w, qn;
    logic [8:0]  lo9, hi9;
    logic        c7, c15, arith;
    exp_t        e;
    @(negedge clk_i);
    instr_i = {d, f, s}; a_addr_i = a; b_addr_i = b; mode8_i = m8;
    byte_sw_i = bsw; swap_i = sw; cin_i = ci; bus_i = bus;
    alo = {a[3:1], a[0] ^ m8};
    blo = m8 ? {b[3:1], ~b[0]} : (bsw ? {b[3:1], 1'b0} : b);
    ra = {mem_m[a][15:8], mem_m[alo][7:0]};
    rb = {mem_m[b][15:8], mem_m[blo][7:0]};
    dw = sw ? {ra[7:0], ra[15:8]} : {bus, bus};
    case (s)
      3'd0: begin r = ra; sv = q_m; end
      3'd1: begin r = ra; sv = rb; end
      3'd2: begin r = 0;  sv = q_m; end
      3'd3: begin r = 0;  sv = rb; end
      3'd4: begin r = 0;  sv = ra; end
      3'd5: begin r = dw; sv = ra; end
      3'd6: begin r = dw; sv = q_m; end
      default: begin r = dw; sv = 0; end
    endcase
    arith = (f <= 3'd2);
    x = (f == 3'd1) ? sv : r;
    yv = (f == 3'd0) ? sv : (f == 3'd1) ? ~r : ~sv;
    lo9 = {1'b0, x[7:0]} + {1'b0, yv[7:0]} + {8'd0, ci};
    hi9 = {1'b0, x[15:8]} + {1'b0, yv[15:8]} + {8'd0, (m8 ? ci : lo9[8])};
    case (f)
      3'd3: fw = r | sv;
      3'd4: fw = r & sv;
      3'd5: fw = ~r & sv;
      3'd6: fw = r ^ sv;
      3'd7: fw = ~(r ^ sv);
      default: fw = {hi9[7:0], lo9[7:0]};
    endcase
    c7  = arith ? lo9[8] : 1'b0;
    c15 = arith ? hi9[8] : 1'b0;
    e.y = (d == 3'd2) ? ra : fw;
    e.c7 = c7; e.c15 = c15;
    e.z = m8 ? (fw[15:8] == 0) : (fw == 0);
    e.tag = tag;
    sb.push_back(e);
    #2 -> chk_ev;
    #1;
    // model state update for the coming edge
    qn = q_m; w = fw;
    case (d)
      3'd0: qn = fw;
      3'd4: begin w = {1'b0, fw[15:1]}; qn = {fw[0], q_m[15:1]}; end
      3'd5: w = {1'b0, fw[15:1]};
      3'd6: begin w = {fw[14:0], q_m[15]}; qn = {q_m[14:0], 1'b0}; end
      3'd7: w = {fw[14:0], 1'b0};
      default: ;
    endcase
    if (d >= 3'd2) begin
      mem_m[b][15:8]  = w[15:8];
      mem_m[blo][7:0] = w[7:0];
    end
    q_m = qn;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(3'd1, 3'd3, 3'd4, a, 4'd14, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic load_pair(input logic [3:0] k, input logic [15:0] v);
    step(3'd3, 3'd3, 3'd7, 4'd0, 2*k,   1'b0, 1'b0, 1'b0, 1'b0, v[7:0],  "R6 load lo");
    step(3'd3, 3'd3, 3'd7, 4'd0, 2*k,   1'b1, 1'b0, 1'b0, 1'b0, v[15:8], "R3 load hi");
    step(3'd2, 3'd3, 3'd7, 2*k,  2*k+1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00,   "R6 resync");
  endtask

  task automatic pair_ok(input logic [3:0] k, input string tag);
    logic [15:0] n;
    rd(2*k, tag);
    n = obs_y;
    rd(2*k+1, tag);
    n_vec++;
    if (obs_y !== {n[7:0], n[15:8]}) begin
      n_bad++;
      $display("FAIL %s pair %0d: swapped=%h expected %h", tag, k, obs_y, {n[7:0], n[15:8]});
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    q_m = '0;
    #22 rst_ni = 1'b1;
    rd(4'd0, "R1 reset entry0");
    rd(4'd15, "R1 reset entry15");
    step(3'd1, 3'd3, 3'd2, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R1 reset Q");
    load_pair(4'd0, 16'h12FF);
    load_pair(4'd1, 16'h3456);
    load_pair(4'd2, 16'h7880);
    load_pair(4'd3, 16'h8011);
    for (int k = 0; k < 4; k++) pair_ok(4'(k), "R9 preload");
    // MOV B,E
    step(3'd3, 3'd3, 3'd4, 4'd3, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R9 move B<-E");
    pair_ok(4'd0, "R9 after move");
    // ADD A,L : 80h + 80h wraps to 0
    step(3'd3, 3'd0, 3'd1, 4'd5, 4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R7 R8 byte add");
    pair_ok(4'd3, "R9 after add");
    // ADC with carry-in, 8-bit lane cut
    step(3'd3, 3'd0, 3'd1, 4'd5, 4'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, "R7 byte adc");
    pair_ok(4'd1, "R9 after adc");
    // INX B and resync
    step(3'd3, 3'd0, 3'd3, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R10 inc");
    step(3'd2, 3'd3, 3'd7, 4'd0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R10 resync");
    pair_ok(4'd0, "R10 after inc");
    for (int k = 0; k < 4; k++) pair_ok(4'(k), "R9 final");
    // word zero flag
    step(3'd3, 3'd0, 3'd3, 4'd0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R8 word zero");
    // byte switch in 16-bit mode
    step(3'd3, 3'd3, 3'd7, 4'd0, 4'd11, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, "R4 byte switch");
    rd(4'd11, "R4 entry11");
    rd(4'd10, "R4 entry10");
    // Q load, pass, no write
    step(3'd0, 3'd3, 3'd4, 4'd2, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 load Q");
    step(3'd1, 3'd6, 3'd1, 4'd2, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R2 xor pass");
    rd(4'd4, "R5 no write");
    step(3'd1, 3'd3, 3'd2, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 read Q");
    // shifts on scratch entry 8
    step(3'd3, 3'd3, 3'd7, 4'd0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, "R6 bus word");
    step(3'd5, 3'd3, 3'd3, 4'd0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 shr");
    rd(4'd8, "R5 shr result");
    step(3'd6, 3'd3, 3'd3, 4'd0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 shl rq");
    rd(4'd8, "R5 shl rq result");
    step(3'd4, 3'd3, 3'd3, 4'd0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 shr rq");
    rd(4'd8, "R5 shr rq result");
    step(3'd1, 3'd3, 3'd2, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 Q after shifts");
    step(3'd7, 3'd3, 3'd3, 4'd0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 shl");
    rd(4'd8, "R5 shl result");
    // remaining functions and sources
    step(3'd1, 3'd2, 3'd1, 4'd2, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R2 R7 subs");
    step(3'd1, 3'd1, 3'd1, 4'd2, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R2 R7 subr");
    step(3'd1, 3'd4, 3'd0, 4'd4, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R2 and AQ");
    step(3'd1, 3'd5, 3'd5, 4'd6, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0, "R2 notrs DA");
    step(3'd1, 3'd7, 3'd6, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, "R2 xnor DQ");
    step(3'd1, 3'd0, 3'd1, 4'd2, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R7 word add");
    @(negedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule